// File: doc/BRIEF.md
# Translation Entry Write Controller

This block carries out the privileged "write translation entry" operation for two small fully associative translation arrays: a 16-entry instruction-side array and a 32-entry data-side array. Each request carries a 2-bit target selector, a 2-bit write-select code, an address operand and a 64-bit data operand. From these the block drives a write strobe for one array, the entry index, and the assembled entry fields. Those fields are the page number, the permission bits, a size code, a staged real-page value and a set of context values taken from a control register. Selector values that are reserved raise an illegal-operation flag instead of a write.

Each side keeps its own state: a staging real-page register, a replacement watermark and a round-robin victim pointer. When round-robin replacement is enabled for a side, the pointer chooses the entry and wraps at the watermark instead of at the array size. When it is disabled, the address operand chooses the entry. Requests arrive on a valid/ready handshake. The block accepts one request every cycle, so `req_ready` is held high and there is never any back-pressure. Results appear on registered outputs in the cycle after acceptance and last one cycle.

Top module: `trans_entry_writer`

## Requirements
- R1: An accepted request with selector 2 and write-select code 0 pulses `iarr_we` in the next cycle. Selector 3 with code 0 pulses `darr_we` instead. At most one strobe is high in any cycle.
- R2: An accepted request with selector 0 or 1 sets `illegal_o` in the next cycle. It raises no strobe and leaves every pointer, watermark and staging register unchanged, whatever its write-select code.
- R3: With round-robin disabled for the chosen side, `wr_index` equals the low 4 address bits on the instruction side and the low 5 address bits on the data side, zero-extended to 5 bits.
- R4: With round-robin enabled, a code-0 write uses the side's pointer as its index. The pointer then becomes (index + 1) mod (watermark + 1). If the pointer lies above the watermark, the write uses index 0.
- R5: Code 1 loads the side's 64-bit staging register from the data operand. A later code-0 write on that side outputs the staged value on `ent_rpn`.
- R6: Code 3 loads the side's watermark from data bits [3:0] on the instruction side and data bits [4:0] on the data side.
- R7: A code-0 write outputs the page number as data[63:12] and the valid/execute pair as data[11:10]. The size code is {data[9:8], 1'b1}.
- R8: If the side's class mode bit is set, the class output is pid[5:4]; otherwise it is data[13:12]. If the side's thread mode bit is set, the thread-enable output is pid[3:0]; otherwise it is data[7:4].
- R9: A code-0 write copies the guest-state, address-space, process-ID, process-ID-nonzero and extended-class control inputs to the matching entry outputs.
- R10: Pointers, watermarks, staging registers and round-robin enables are separate for each side. An operation on one side never changes the other side's results.
- R11: Code 2 with a legal selector raises no strobe, does not set `illegal_o` and changes no state.
- R12: After reset both pointers are 0, the watermarks are 15 and 31, and all strobes and `illegal_o` are low.
- R13: `req_ready` is always 1. A cycle without `req_valid` produces no strobe and no illegal flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_sel | input | 2 | Target selector: 2 instruction side, 3 data side, 0/1 reserved |
| req_ws | input | 2 | Write-select code: 0 entry, 1 staging, 2 no-op, 3 watermark |
| req_addr | input | 64 | Address operand |
| req_data | input | 64 | Data operand |
| rr_en_i | input | 1 | Round-robin enable, instruction side |
| rr_en_d | input | 1 | Round-robin enable, data side |
| cls_pid_i | input | 1 | Class from process-ID, instruction side |
| cls_pid_d | input | 1 | Class from process-ID, data side |
| thd_pid_i | input | 1 | Thread field from process-ID, instruction side |
| thd_pid_d | input | 1 | Thread field from process-ID, data side |
| ctx_pid | input | 14 | Process-ID |
| ctx_pidnz | input | 1 | Process-ID nonzero flag |
| ctx_gs | input | 1 | Guest-state bit |
| ctx_as | input | 1 | Address-space bit |
| ctx_ecl | input | 1 | Extended class bit |
| iarr_we | output | 1 | Instruction-side array write strobe |
| darr_we | output | 1 | Data-side array write strobe |
| illegal_o | output | 1 | Illegal-operation pulse |
| wr_index | output | 5 | Entry index |
| ent_epn | output | 52 | Page number |
| ent_vx | output | 2 | Valid and execute bits |
| ent_size | output | 3 | Size code |
| ent_rpn | output | 64 | Staged real-page value |
| ent_class | output | 2 | Class field |
| ent_thd | output | 4 | Thread-enable field |
| ent_gs | output | 1 | Guest-state copy |
| ent_as | output | 1 | Address-space copy |
| ent_pid | output | 14 | Process-ID copy |
| ent_pidnz | output | 1 | Process-ID-nonzero copy |
| ent_ecl | output | 1 | Extended class copy |

## Verification
Every result is due exactly one cycle after the clock edge that accepts the request: strobes, index, entry fields and the illegal flag. Pointer, watermark and staging updates take effect at that same edge, so they first show up in the index or real-page value of the next request. The bench drives each request on a falling edge and lets one rising edge capture it. It samples on the following falling edge, then drops `req_valid`. A per-side arithmetic model predicts the index and staged value for each write.

// File: rtl/tew_pkg.sv
package tew_pkg;
  localparam int DATA_W = 64;
  localparam int EPN_W  = 52;
  localparam int PID_W  = 14;

  typedef enum logic [1:0] {
    WS_ENTRY = 2'd0,
    WS_STAGE = 2'd1,
    WS_NOP   = 2'd2,
    WS_WMARK = 2'd3
  } ws_e;

  typedef struct packed {
    logic [EPN_W-1:0]  epn;
    logic [1:0]        vx;
    logic [2:0]        size;
    logic [DATA_W-1:0] rpn;
    logic [1:0]        cls;
    logic [3:0]        thd;
    logic              gs;
    logic              as_b;
    logic [PID_W-1:0]  pid;
    logic              pidnz;
    logic              ecl;
  } entry_t;
endpackage

// File: rtl/tew_side.sv
module tew_side
  import tew_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [1:0]        ws,
  input  logic              rr_en,
  input  logic [IW-1:0]     addr_lo,
  input  logic [DATA_W-1:0] data,
  output logic [IW-1:0]     idx_o,
  output logic [DATA_W-1:0] stage_o
);
  logic [IW-1:0] ptr_q, wm_q, rr_idx;

  assign rr_idx = (ptr_q > wm_q) ? '0 : ptr_q;
  assign idx_o  = rr_en ? rr_idx : addr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      wm_q    <= IW'(DEPTH - 1);
      stage_o <= '0;
    end else if (hit) begin
      unique case (ws_e'(ws))
        WS_ENTRY: if (rr_en) ptr_q <= (rr_idx == wm_q) ? '0 : rr_idx + 1'b1;
        WS_STAGE: stage_o <= data;
        WS_WMARK: wm_q <= data[IW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tew_pack.sv
module tew_pack
  import tew_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] stage,
  input  logic              cls_pid,
  input  logic              thd_pid,
  input  logic [PID_W-1:0]  pid,
  input  logic              pidnz,
  input  logic              gs,
  input  logic              as_b,
  input  logic              ecl,
  output entry_t            ent
);
  always_comb begin
    ent.epn   = data[DATA_W-1:DATA_W-EPN_W];
    ent.vx    = data[11:10];
    ent.size  = {data[9:8], 1'b1};
    ent.rpn   = stage;
    ent.cls   = cls_pid ? pid[5:4] : data[13:12];
    ent.thd   = thd_pid ? pid[3:0] : data[7:4];
    ent.gs    = gs;
    ent.as_b  = as_b;
    ent.pid   = pid;
    ent.pidnz = pidnz;
    ent.ecl   = ecl;
  end
endmodule

// File: rtl/trans_entry_writer.sv
module trans_entry_writer
  import tew_pkg::*;
#(
  parameter int I_DEPTH = 16,
  parameter int D_DEPTH = 32,
  localparam int I_IW  = $clog2(I_DEPTH),
  localparam int D_IW  = $clog2(D_DEPTH),
  localparam int IDX_W = (I_IW > D_IW) ? I_IW : D_IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_sel,
  input  logic [1:0]        req_ws,
  input  logic [63:0]       req_addr,
  input  logic [63:0]       req_data,
  input  logic              rr_en_i,
  input  logic              rr_en_d,
  input  logic              cls_pid_i,
  input  logic              cls_pid_d,
  input  logic              thd_pid_i,
  input  logic              thd_pid_d,
  input  logic [13:0]       ctx_pid,
  input  logic              ctx_pidnz,
  input  logic              ctx_gs,
  input  logic              ctx_as,
  input  logic              ctx_ecl,
  output logic              iarr_we,
  output logic              darr_we,
  output logic              illegal_o,
  output logic [IDX_W-1:0]  wr_index,
  output logic [51:0]       ent_epn,
  output logic [1:0]        ent_vx,
  output logic [2:0]        ent_size,
  output logic [63:0]       ent_rpn,
  output logic [1:0]        ent_class,
  output logic [3:0]        ent_thd,
  output logic              ent_gs,
  output logic              ent_as,
  output logic [13:0]       ent_pid,
  output logic              ent_pidnz,
  output logic              ent_ecl
);
  localparam logic [1:0] SEL_I = 2'd2;
  localparam logic [1:0] SEL_D = 2'd3;

  logic              hit_i, hit_d, is_d;
  logic [I_IW-1:0]   idx_i;
  logic [D_IW-1:0]   idx_d;
  logic [63:0]       stage_i, stage_d;
  entry_t            ent_nx, ent_q;
  logic [IDX_W-1:0]  idx_nx;

  assign req_ready = 1'b1;
  assign hit_i = req_valid && (req_sel == SEL_I);
  assign hit_d = req_valid && (req_sel == SEL_D);
  assign is_d  = (req_sel == SEL_D);

  tew_side #(.DEPTH(I_DEPTH)) u_side_i (
    .clk(clk), .rst_n(rst_n), .hit(hit_i), .ws(req_ws), .rr_en(rr_en_i),
    .addr_lo(req_addr[I_IW-1:0]), .data(req_data), .idx_o(idx_i), .stage_o(stage_i)
  );

  tew_side #(.DEPTH(D_DEPTH)) u_side_d (
    .clk(clk), .rst_n(rst_n), .hit(hit_d), .ws(req_ws), .rr_en(rr_en_d),
    .addr_lo(req_addr[D_IW-1:0]), .data(req_data), .idx_o(idx_d), .stage_o(stage_d)
  );

  tew_pack u_pack (
    .data(req_data),
    .stage(is_d ? stage_d : stage_i),
    .cls_pid(is_d ? cls_pid_d : cls_pid_i),
    .thd_pid(is_d ? thd_pid_d : thd_pid_i),
    .pid(ctx_pid), .pidnz(ctx_pidnz), .gs(ctx_gs), .as_b(ctx_as), .ecl(ctx_ecl),
    .ent(ent_nx)
  );

  assign idx_nx = is_d ? IDX_W'(idx_d) : IDX_W'(idx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iarr_we   <= 1'b0;
      darr_we   <= 1'b0;
      illegal_o <= 1'b0;
      wr_index  <= '0;
      ent_q     <= '0;
    end else begin
      iarr_we   <= hit_i && (req_ws == WS_ENTRY);
      darr_we   <= hit_d && (req_ws == WS_ENTRY);
      illegal_o <= req_valid && !req_sel[1];
      if (req_valid) begin
        wr_index <= idx_nx;
        ent_q    <= ent_nx;
      end
    end
  end

  assign ent_epn   = ent_q.epn;
  assign ent_vx    = ent_q.vx;
  assign ent_size  = ent_q.size;
  assign ent_rpn   = ent_q.rpn;
  assign ent_class = ent_q.cls;
  assign ent_thd   = ent_q.thd;
  assign ent_gs    = ent_q.gs;
  assign ent_as    = ent_q.as_b;
  assign ent_pid   = ent_q.pid;
  assign ent_pidnz = ent_q.pidnz;
  assign ent_ecl   = ent_q.ecl;
endmodule

// File: rtl/tew_checker.sv
module tew_checker #(
  parameter int I_DEPTH = 16,
  parameter int IDX_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_sel,
  input logic [1:0]       req_ws,
  input logic             iarr_we,
  input logic             darr_we,
  input logic             illegal_o,
  input logic [IDX_W-1:0] wr_index
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iarr_we, darr_we})); // R1
  AST_I_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel == 2'd2 && req_ws == 2'd0) |=> iarr_we); // R1
  AST_D_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel == 2'd3 && req_ws == 2'd0) |=> darr_we); // R1
  AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sel[1]) |=> (illegal_o && !iarr_we && !darr_we)); // R2
  AST_I_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iarr_we |-> (int'(wr_index) < I_DEPTH)); // R3
  AST_CODE2_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel[1] && req_ws == 2'd2) |=> (!iarr_we && !darr_we && !illegal_o)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!iarr_we && !darr_we && !illegal_o)); // R13
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R13
endmodule

bind trans_entry_writer tew_checker #(.I_DEPTH(I_DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sel(req_sel), .req_ws(req_ws), .iarr_we(iarr_we), .darr_we(darr_we),
  .illegal_o(illegal_o), .wr_index(wr_index)
);

// File: tb/trans_entry_writer_test.sv
module trans_entry_writer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_sel = '0, req_ws = '0;
  logic [63:0] req_addr = '0, req_data = '0;
  logic rr_en_i = 0, rr_en_d = 0, cls_pid_i = 0, cls_pid_d = 0, thd_pid_i = 0, thd_pid_d = 0;
  logic [13:0] ctx_pid = 14'h2A5;
  logic ctx_pidnz = 1, ctx_gs = 0, ctx_as = 1, ctx_ecl = 0;
  logic iarr_we, darr_we, illegal_o;
  logic [4:0] wr_index;
  logic [51:0] ent_epn;
  logic [1:0] ent_vx, ent_class;
  logic [2:0] ent_size;
  logic [63:0] ent_rpn;
  logic [3:0] ent_thd;
  logic ent_gs, ent_as, ent_pidnz, ent_ecl;
  logic [13:0] ent_pid;

  int checks = 0;
  int errors = 0;
  int m_ptr[2], m_wm[2];
  logic [63:0] m_stage[2];

  always #4 clk = ~clk;

  trans_entry_writer uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] s, input logic [1:0] w,
                    input logic [63:0] a, input logic [63:0] d, input string tag);
    bit legal = s[1];
    int sd = (s == 2'd3) ? 1 : 0;
    bit rr = sd ? rr_en_d : rr_en_i;
    bit cm = sd ? cls_pid_d : cls_pid_i;
    bit tm = sd ? thd_pid_d : thd_pid_i;
    int idx;
    logic [63:0] rpn = m_stage[sd];
    if (rr) idx = (m_ptr[sd] > m_wm[sd]) ? 0 : m_ptr[sd];
    else idx = sd ? int'(a[4:0]) : int'(a[3:0]);
    if (legal) begin
      if (w == 2'd0 && rr) m_ptr[sd] = (idx == m_wm[sd]) ? 0 : idx + 1;
      if (w == 2'd1) m_stage[sd] = d;
      if (w == 2'd3) m_wm[sd] = sd ? int'(d[4:0]) : int'(d[3:0]);
    end
    req_valid = 1; req_sel = s; req_ws = w; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R1 istrobe"}, iarr_we, legal && sd == 0 && w == 0);
    chk({tag, " R1 dstrobe"}, darr_we, legal && sd == 1 && w == 0);
    chk({tag, " R2 illegal"}, illegal_o, !legal);
    if (legal && w == 0) begin
      chk({tag, " index"}, wr_index, idx);
      chk({tag, " R5 rpn"}, ent_rpn, rpn);
      chk({tag, " R7 epn"}, ent_epn, d[63:12]);
      chk({tag, " R7 vx"}, ent_vx, d[11:10]);
      chk({tag, " R7 size"}, ent_size, {d[9:8], 1'b1});
      chk({tag, " R8 class"}, ent_class, cm ? ctx_pid[5:4] : d[13:12]);
      chk({tag, " R8 thd"}, ent_thd, tm ? ctx_pid[3:0] : d[7:4]);
      chk({tag, " R9 ctx"}, {ent_gs, ent_as, ent_pid, ent_pidnz, ent_ecl},
          {ctx_gs, ctx_as, ctx_pid, ctx_pidnz, ctx_ecl});
    end
  endtask

  function automatic logic [63:0] mix(input int k);
    return {32'h9E3779B9 * (k + 1), 32'h85EBCA6B ^ (k * 2654435)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_ptr[0] = 0; m_ptr[1] = 0; m_wm[0] = 15; m_wm[1] = 31;
    m_stage[0] = '0; m_stage[1] = '0;
    repeat (2) @(negedge clk);
    chk("R12 reset strobes", {iarr_we, darr_we, illegal_o}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R13 ready", req_ready, 1'b1);
    chk("R13 idle", {iarr_we, darr_we, illegal_o}, 3'b000);

    // R12: reset pointer 0 and watermark max, seen through a full round-robin lap
    rr_en_i = 1; rr_en_d = 1;
    for (int k = 0; k < 20; k++) op(2'd2, 2'd0, 64'h0, mix(k), "R12 R4 i-lap");
    for (int k = 0; k < 36; k++) op(2'd3, 2'd0, 64'h0, mix(k + 50), "R12 R4 d-lap");

    // R3: direct addressing sweep on both sides, with noise in upper address bits
    rr_en_i = 0; rr_en_d = 0;
    for (int a = 0; a < 16; a++) op(2'd2, 2'd0, {mix(a)[63:8], 8'(a) | 8'hF0}, mix(a + 7), "R3 i-addr");
    for (int a = 0; a < 32; a++) op(2'd3, 2'd0, {mix(a)[63:8], 8'(a) | 8'hE0}, mix(a + 9), "R3 d-addr");

    // R5 / R10: staging registers are per side
    op(2'd2, 2'd1, 64'h0, 64'h1111_2222_3333_4444, "R5 stage-i");
    op(2'd3, 2'd1, 64'h0, 64'hAAAA_BBBB_CCCC_DDDD, "R5 stage-d");
    op(2'd2, 2'd0, 64'h3, mix(101), "R10 i-rpn");
    op(2'd3, 2'd0, 64'h13, mix(102), "R10 d-rpn");

    // R6 / R4: watermark sweeps with round-robin
    rr_en_i = 1; rr_en_d = 1;
    for (int wm = 0; wm < 16; wm += 5) begin
      op(2'd2, 2'd3, 64'h0, 64'(wm), "R6 i-wm");
      for (int k = 0; k < wm + 3; k++) op(2'd2, 2'd0, 64'h0, mix(k + wm), "R4 i-wrap");
    end
    for (int wm = 1; wm < 32; wm += 9) begin
      op(2'd3, 2'd3, 64'h0, 64'(wm), "R6 d-wm");
      for (int k = 0; k < wm + 3; k++) op(2'd3, 2'd0, 64'h0, mix(k + wm + 3), "R4 d-wrap");
    end
    // R4: pointer above a lowered watermark restarts at entry 0
    op(2'd3, 2'd3, 64'h0, 64'd31, "R6 d-wm-max");
    for (int k = 0; k < 10; k++) op(2'd3, 2'd0, 64'h0, mix(k), "R4 d-advance");
    op(2'd3, 2'd3, 64'h0, 64'd4, "R6 d-wm-low");
    for (int k = 0; k < 7; k++) op(2'd3, 2'd0, 64'h0, mix(k + 3), "R4 d-above-wm");

    // R2: reserved selectors with every code leave all state unchanged
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++) op(2'(s), 2'(w), 64'h1F, 64'hFFFF_FFFF_FFFF_FFF0 | 64'(w), "R2 reserved");
    op(2'd3, 2'd0, 64'h0, mix(7), "R2 d-after");
    op(2'd2, 2'd0, 64'h0, mix(8), "R2 i-after");

    // R11: code 2 on each side is a no-op
    op(2'd2, 2'd2, 64'h0, 64'h5, "R11 nop-i");
    op(2'd3, 2'd2, 64'h0, 64'h5, "R11 nop-d");
    op(2'd2, 2'd0, 64'h0, mix(9), "R11 i-after");
    op(2'd3, 2'd0, 64'h0, mix(10), "R11 d-after");

    // R8 / R9: field sources under every mode combination
    for (int m = 0; m < 16; m++) begin
      {cls_pid_i, thd_pid_i, cls_pid_d, thd_pid_d} = 4'(m);
      ctx_pid = 14'(m * 977); {ctx_gs, ctx_as, ctx_pidnz, ctx_ecl} = 4'(m ^ 5);
      op(2'd2, 2'd0, 64'(m), mix(m + 200), "R8 i-modes");
      op(2'd3, 2'd0, 64'(m), mix(m + 300), "R8 d-modes");
    end

    @(negedge clk);
    chk("R13 idle end", {iarr_we, darr_we, illegal_o}, 3'b000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule